// File: doc/BRIEF.md
# Per-Producer Token Credit Allocator

This block sits on the consumer side of a shared receive buffer that several producers fill. Producers are first enrolled by index. A single init pulse then splits the buffer capacity, counted in flits, evenly among the enrolled producers. Each producer gets a private pool of tokens equal to the capacity divided by the number enrolled, using integer division. Enrolment closes at that point.

Each request carries a producer index and a byte length. It costs the byte length divided by the flit size, rounded down, in tokens. The request is granted only if the producer's own pool covers the whole cost, and the pool is then debited by that cost. When the buffer frees an entry, a release carries the same index and byte length. The cost is credited back to that pool and a one-cycle notify pulse goes out toward the producer.

A grant or denial, a notify, an identity error and an overflow error all appear as registered pulses one clock after the input that caused them.

Top module: `token_credit_alloc`

## Requirements
- R1: An enrol request for index i (0 to NPROD-1) is taken only before initialisation and only once per index. Repeat enrolments and enrolments after initialisation change neither the producer count nor any pool.
- R2: A successful init loads every enrolled pool with floor(BUF_FLITS / count), where count is the number of distinct enrolled indices.
- R3: An init pulse with zero enrolled producers, or with more producers than BUF_FLITS, raises `init_err` and leaves `ready` low. A successful init drives `ready` high and clears `init_err`. `ready` then stays high until reset, and later init pulses are ignored.
- R4: Every query cycle produces, one clock later, exactly one of `gnt_valid` or `dny_valid`, with `rsp_id` equal to the queried index. A cycle with no query produces neither.
- R5: A query costs floor(size / FLIT_BYTES) tokens. It is granted when the pool holds at least that many tokens, and the pool is debited by the cost. A zero-cost query is always granted to a live producer.
- R6: A denied query leaves the pool unchanged.
- R7: A release from a live producer credits floor(size / FLIT_BYTES) tokens to its pool. One clock later it pulses `ntf_valid`, with `ntf_id` and `ntf_size` copied from the release.
- R8: When a query and a release name the same producer in one cycle, the grant decision uses the count before the release. The new count is old + returned - granted.
- R9: A query or release naming an index that was never enrolled pulses `id_err` one clock later. Such a query is denied, such a release gives no notify, and no pool changes.
- R10: If an update would leave a pool above its initial share, `ovf_err` pulses one clock later and the pool is clamped to the share.
- R11: After reset all outputs are low. Before `ready`, queries from enrolled producers are denied without `id_err`, and releases are dropped without notify.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Enrol a producer this cycle |
| reg_id | input | ID_W | Index being enrolled |
| init_start | input | 1 | Split the buffer among enrolled producers |
| q_valid | input | 1 | Token query present |
| q_id | input | ID_W | Querying producer |
| q_size | input | SIZE_W | Query length in bytes |
| rel_valid | input | 1 | Buffer entry freed |
| rel_id | input | ID_W | Producer owning the freed entry |
| rel_size | input | SIZE_W | Freed length in bytes |
| ready | output | 1 | Pools initialised |
| init_err | output | 1 | Last init attempt rejected |
| gnt_valid | output | 1 | Query granted (pulse) |
| dny_valid | output | 1 | Query denied (pulse) |
| rsp_id | output | ID_W | Producer the response belongs to |
| ntf_valid | output | 1 | Tokens returned (pulse) |
| ntf_id | output | ID_W | Producer being notified |
| ntf_size | output | SIZE_W | Byte length returned |
| id_err | output | 1 | Query or release from a non-enrolled index (pulse) |
| ovf_err | output | 1 | A pool exceeded its share (pulse) |

## Verification
A pool count that goes wrong is not visible directly. It shows up at the next query to that producer, as a grant where the bench expects a denial or the reverse, one clock after the query. The sweeps therefore follow each change of a pool with queries whose costs straddle the expected count. A wrong producer count at init shows the same way, because the share it yields sets the exact cost at which grants turn into denials. Clamping, merged updates and identity errors are each probed in the cycle right after the stimulus, through the pulses and then through follow-up queries.

// File: rtl/tcred_pkg.sv
// Shared definitions for the token credit allocator.
package tcred_pkg;
    // Allocator phase: enrolment open, or pools live.
    typedef enum logic {
        PH_COLLECT = 1'b0,
        PH_ACTIVE  = 1'b1
    } tcred_phase_e;

    // Larger of two integers, for deriving widths.
    function automatic int tcred_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/tcred_setup.sv
// Enrolment and initialisation control.
// Tracks which producer indices are enrolled and how many, and switches to
// the active phase on a valid init pulse. It also yields the per-producer
// share, taken from a table of constant quotients.
// Assumes: enrolment and init are meaningful only in the collect phase.
module tcred_setup
    import tcred_pkg::*;
#(
    parameter int NPROD     = 4,
    parameter int BUF_FLITS = 100,
    parameter int ID_W      = 2,
    parameter int CNT_W     = 7,
    parameter int PC_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic [ID_W-1:0]   reg_id,
    input  logic              init_start,
    output logic [NPROD-1:0]  reg_mask,
    output tcred_phase_e      phase,
    output logic              load,
    output logic [CNT_W-1:0]  share,
    output logic              init_err
);
    logic [PC_W-1:0]  count;
    logic [CNT_W-1:0] share_tbl [NPROD+1];
    logic             reg_take;
    logic             init_ok;

    // Constant quotient table indexed by producer count.
    for (genvar g = 0; g <= NPROD; g++) begin : g_share
        if (g == 0) begin : g_zero
            assign share_tbl[g] = '0;
        end else begin : g_div
            assign share_tbl[g] = CNT_W'(BUF_FLITS / g);
        end
    end

    assign share = share_tbl[count];

    // Decide whether this cycle's enrolment and init are accepted.
    always_comb begin
        reg_take = reg_valid && (phase == PH_COLLECT) &&
                   (int'(reg_id) < NPROD) && !reg_mask[reg_id];
        init_ok  = (count != '0) && (int'(count) <= BUF_FLITS);
        load     = init_start && (phase == PH_COLLECT) && init_ok;
    end

    // Enrolment bookkeeping and phase switch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_mask <= '0;
            count    <= '0;
            phase    <= PH_COLLECT;
            init_err <= 1'b0;
        end else begin
            if (reg_take) begin
                reg_mask[reg_id] <= 1'b1;
                count            <= count + 1'b1;
            end
            if (init_start && phase == PH_COLLECT) begin
                if (init_ok) begin
                    phase    <= PH_ACTIVE;
                    init_err <= 1'b0;
                end else begin
                    init_err <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tcred_cost.sv
// Converts a byte length into a token count by flooring division by the
// flit size. Purely combinational; assumes FLIT_BYTES >= 1.
module tcred_cost #(
    parameter int SIZE_W     = 16,
    parameter int FLIT_BYTES = 64,
    parameter int TOK_W      = 16
) (
    input  logic [SIZE_W-1:0] size,
    output logic [TOK_W-1:0]  tokens
);
    localparam int DIV_W = (SIZE_W > 32) ? SIZE_W : 32;

    // Floor of length over flit size.
    always_comb begin
        tokens = TOK_W'(DIV_W'(size) / DIV_W'(FLIT_BYTES));
    end
endmodule

// File: rtl/tcred_pool.sv
// One producer's private token pool.
// It is loaded with the share at init, then debited by granted queries and
// credited by releases. A query and a release in the same cycle merge into
// one update. A result above the share is clamped and flagged.
// Assumes: q_hit/r_hit are asserted only for a live, enrolled producer.
module tcred_pool #(
    parameter int CNT_W = 7,
    parameter int TOK_W = 16,
    parameter int SUM_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] share,
    input  logic             q_hit,
    input  logic [TOK_W-1:0] q_tok,
    input  logic             r_hit,
    input  logic [TOK_W-1:0] r_tok,
    output logic             can_take,
    output logic             ovf_now
);
    logic [CNT_W-1:0] level;
    logic [SUM_W-1:0] lvl_x;
    logic [SUM_W-1:0] share_x;
    logic [SUM_W-1:0] take_x;
    logic [SUM_W-1:0] give_x;
    logic [SUM_W-1:0] nxt_x;

    // Merged next count and overflow detection.
    always_comb begin
        lvl_x    = {{(SUM_W-CNT_W){1'b0}}, level};
        share_x  = {{(SUM_W-CNT_W){1'b0}}, share};
        can_take = lvl_x >= {{(SUM_W-TOK_W){1'b0}}, q_tok};
        take_x   = (q_hit && can_take) ? {{(SUM_W-TOK_W){1'b0}}, q_tok} : '0;
        give_x   = r_hit ? {{(SUM_W-TOK_W){1'b0}}, r_tok} : '0;
        nxt_x    = lvl_x + give_x - take_x;
        ovf_now  = (q_hit || r_hit) && (nxt_x > share_x);
    end

    // Pool counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else if (load) begin
            level <= share;
        end else if (q_hit || r_hit) begin
            level <= ovf_now ? share : nxt_x[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/token_credit_alloc.sv
// Per-producer token credit allocator, top level.
// Guards a shared receive buffer of BUF_FLITS flits split evenly among up to
// NPROD producers. Queries are answered with a grant or deny pulse one clock
// later. Releases return tokens and pulse a notify one clock later.
// Assumes: one query and one release port, each at most one per cycle.
module token_credit_alloc
    import tcred_pkg::*;
#(
    parameter int NPROD      = 4,
    parameter int BUF_FLITS  = 100,
    parameter int FLIT_BYTES = 64,
    parameter int SIZE_W     = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_valid,
    input  logic [((NPROD>1)?$clog2(NPROD):1)-1:0] reg_id,
    input  logic                     init_start,
    input  logic                     q_valid,
    input  logic [((NPROD>1)?$clog2(NPROD):1)-1:0] q_id,
    input  logic [SIZE_W-1:0]        q_size,
    input  logic                     rel_valid,
    input  logic [((NPROD>1)?$clog2(NPROD):1)-1:0] rel_id,
    input  logic [SIZE_W-1:0]        rel_size,
    output logic                     ready,
    output logic                     init_err,
    output logic                     gnt_valid,
    output logic                     dny_valid,
    output logic [((NPROD>1)?$clog2(NPROD):1)-1:0] rsp_id,
    output logic                     ntf_valid,
    output logic [((NPROD>1)?$clog2(NPROD):1)-1:0] ntf_id,
    output logic [SIZE_W-1:0]        ntf_size,
    output logic                     id_err,
    output logic                     ovf_err
);
    localparam int ID_W  = (NPROD > 1) ? $clog2(NPROD) : 1;
    localparam int CNT_W = $clog2(BUF_FLITS + 1);
    localparam int PC_W  = $clog2(NPROD + 1);
    localparam int TOK_W = SIZE_W;
    localparam int SUM_W = tcred_max(CNT_W, TOK_W) + 1;

    logic [NPROD-1:0] reg_mask;
    tcred_phase_e     phase;
    logic             load;
    logic [CNT_W-1:0] share;
    logic [TOK_W-1:0] q_tok;
    logic [TOK_W-1:0] r_tok;
    logic [NPROD-1:0] can_take;
    logic [NPROD-1:0] ovf_vec;
    logic             q_known, q_live, r_known, r_live, grant_now;

    tcred_setup #(
        .NPROD(NPROD), .BUF_FLITS(BUF_FLITS), .ID_W(ID_W),
        .CNT_W(CNT_W), .PC_W(PC_W)
    ) u_setup (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_id(reg_id),
        .init_start(init_start), .reg_mask(reg_mask), .phase(phase),
        .load(load), .share(share), .init_err(init_err)
    );

    tcred_cost #(.SIZE_W(SIZE_W), .FLIT_BYTES(FLIT_BYTES), .TOK_W(TOK_W))
        u_qcost (.size(q_size), .tokens(q_tok));

    tcred_cost #(.SIZE_W(SIZE_W), .FLIT_BYTES(FLIT_BYTES), .TOK_W(TOK_W))
        u_rcost (.size(rel_size), .tokens(r_tok));

    // Qualify query and release against enrolment and phase.
    always_comb begin
        q_known   = q_valid && (int'(q_id) < NPROD) && reg_mask[q_id];
        q_live    = q_known && (phase == PH_ACTIVE);
        r_known   = rel_valid && (int'(rel_id) < NPROD) && reg_mask[rel_id];
        r_live    = r_known && (phase == PH_ACTIVE);
        grant_now = q_live && can_take[q_id];
    end

    for (genvar p = 0; p < NPROD; p++) begin : g_pool
        tcred_pool #(.CNT_W(CNT_W), .TOK_W(TOK_W), .SUM_W(SUM_W)) u_pool (
            .clk(clk), .rst_n(rst_n), .load(load && reg_mask[p]),
            .share(share),
            .q_hit(q_live && (int'(q_id) == p)), .q_tok(q_tok),
            .r_hit(r_live && (int'(rel_id) == p)), .r_tok(r_tok),
            .can_take(can_take[p]), .ovf_now(ovf_vec[p])
        );
    end

    assign ready = (phase == PH_ACTIVE);

    // Registered response, notify and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_valid <= 1'b0;
            dny_valid <= 1'b0;
            rsp_id    <= '0;
            ntf_valid <= 1'b0;
            ntf_id    <= '0;
            ntf_size  <= '0;
            id_err    <= 1'b0;
            ovf_err   <= 1'b0;
        end else begin
            gnt_valid <= grant_now;
            dny_valid <= q_valid && !grant_now;
            rsp_id    <= q_valid ? q_id : '0;
            ntf_valid <= r_live;
            ntf_id    <= r_live ? rel_id : '0;
            ntf_size  <= r_live ? rel_size : '0;
            id_err    <= (q_valid && !q_known) || (rel_valid && !r_known);
            ovf_err   <= |ovf_vec;
        end
    end
endmodule

// File: rtl/token_credit_alloc_chk.sv
// Temporal checks on the allocator's ports, attached by bind.
module token_credit_alloc_chk #(
    parameter int ID_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            q_valid,
    input logic [ID_W-1:0] q_id,
    input logic            rel_valid,
    input logic [ID_W-1:0] rel_id,
    input logic            ready,
    input logic            init_err,
    input logic            gnt_valid,
    input logic            dny_valid,
    input logic [ID_W-1:0] rsp_id,
    input logic            ntf_valid,
    input logic [ID_W-1:0] ntf_id,
    input logic            ovf_err
);
    AST_ONE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |=> (gnt_valid ^ dny_valid)); // R4
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |=> !(gnt_valid || dny_valid)); // R4
    AST_RSP_ID: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |=> (rsp_id == $past(q_id))); // R4
    AST_NOT_READY_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && !ready) |=> dny_valid); // R11
    AST_NTF_FROM_REL: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |=> (!ntf_valid || ntf_id == $past(rel_id))); // R7
    AST_NTF_NEEDS_REL: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_valid |=> !ntf_valid); // R7
    AST_OVF_NEEDS_REL: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_valid |=> !ovf_err); // R10
    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready); // R3
    AST_INIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && init_err)); // R3
endmodule

bind token_credit_alloc token_credit_alloc_chk #(.ID_W(ID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_id(q_id),
    .rel_valid(rel_valid), .rel_id(rel_id), .ready(ready),
    .init_err(init_err), .gnt_valid(gnt_valid), .dny_valid(dny_valid),
    .rsp_id(rsp_id), .ntf_valid(ntf_valid), .ntf_id(ntf_id),
    .ovf_err(ovf_err)
);

// File: tb/test_token_credit_alloc.sv
module test_token_credit_alloc;
    localparam int CLK_PERIOD = 10;
    localparam int NP   = 4;
    localparam int BUF  = 10;
    localparam int FLIT = 8;
    localparam int SW   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_valid = 0, init_start = 0, q_valid = 0, rel_valid = 0;
    logic [1:0] reg_id = 0, q_id = 0, rel_id = 0;
    logic [SW-1:0] q_size = 0, rel_size = 0;
    logic ready, init_err, gnt_valid, dny_valid, ntf_valid, id_err, ovf_err;
    logic [1:0] rsp_id, ntf_id;
    logic [SW-1:0] ntf_size;

    logic s_reg_valid = 0, s_init = 0;
    logic [1:0] s_reg_id = 0;
    logic s_ready, s_init_err, s_gnt, s_dny, s_ntf, s_iderr, s_ovf;
    logic [1:0] s_rsp_id, s_ntf_id;
    logic [SW-1:0] s_ntf_size;

    int errors = 0;
    int checks = 0;
    int mpool [NP];
    bit mreg [NP];
    bit mready = 0;
    int mshare = 0;
    bit last_gnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    token_credit_alloc #(.NPROD(NP), .BUF_FLITS(BUF), .FLIT_BYTES(FLIT),
                         .SIZE_W(SW)) i_token_credit_alloc (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_id(reg_id),
        .init_start(init_start), .q_valid(q_valid), .q_id(q_id),
        .q_size(q_size), .rel_valid(rel_valid), .rel_id(rel_id),
        .rel_size(rel_size), .ready(ready), .init_err(init_err),
        .gnt_valid(gnt_valid), .dny_valid(dny_valid), .rsp_id(rsp_id),
        .ntf_valid(ntf_valid), .ntf_id(ntf_id), .ntf_size(ntf_size),
        .id_err(id_err), .ovf_err(ovf_err));

    token_credit_alloc #(.NPROD(NP), .BUF_FLITS(2), .FLIT_BYTES(FLIT),
                         .SIZE_W(SW)) i_token_credit_alloc_small (
        .clk(clk), .rst_n(rst_n), .reg_valid(s_reg_valid), .reg_id(s_reg_id),
        .init_start(s_init), .q_valid(1'b0), .q_id(2'd0),
        .q_size('0), .rel_valid(1'b0), .rel_id(2'd0),
        .rel_size('0), .ready(s_ready), .init_err(s_init_err),
        .gnt_valid(s_gnt), .dny_valid(s_dny), .rsp_id(s_rsp_id),
        .ntf_valid(s_ntf), .ntf_id(s_ntf_id), .ntf_size(s_ntf_size),
        .id_err(s_iderr), .ovf_err(s_ovf));

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic enrol(input int id);
        reg_valid = 1; reg_id = 2'(id);
        @(negedge clk);
        reg_valid = 0;
        if (!mready) mreg[id] = 1;
    endtask

    task automatic do_init(input string tag);
        int cnt = 0;
        bit eerr;
        for (int p = 0; p < NP; p++) cnt += mreg[p];
        eerr = 0;
        if (!mready) begin
            if (cnt == 0 || cnt > BUF) eerr = 1;
            else begin
                mready = 1; mshare = BUF / cnt;
                for (int p = 0; p < NP; p++) if (mreg[p]) mpool[p] = mshare;
            end
        end
        init_start = 1;
        @(negedge clk);
        init_start = 0;
        check(tag, {30'd0, ready, init_err}, {30'd0, mready, eerr});
    endtask

    // One cycle of query and/or release with a model-computed expectation.
    task automatic op(input bit qv, input int qid, input int qsz,
                      input bit rv, input int rid, input int rsz,
                      input string tag);
        bit qk, ql, rk, rl, ok, ovf;
        int cost, rc, nxt;
        qk = qv && mreg[qid]; ql = qk && mready;
        rk = rv && mreg[rid]; rl = rk && mready;
        cost = qsz / FLIT; rc = rsz / FLIT;
        ok = ql && (mpool[qid] >= cost);
        ovf = 0;
        for (int p = 0; p < NP; p++) begin
            if ((ql && qid == p) || (rl && rid == p)) begin
                nxt = mpool[p] + ((rl && rid == p) ? rc : 0)
                               - ((ok && qid == p) ? cost : 0);
                if (nxt > mshare) begin ovf = 1; nxt = mshare; end
                mpool[p] = nxt;
            end
        end
        last_gnt = ok;
        q_valid = qv; q_id = 2'(qid); q_size = SW'(qsz);
        rel_valid = rv; rel_id = 2'(rid); rel_size = SW'(rsz);
        @(negedge clk);
        q_valid = 0; rel_valid = 0;
        check(tag,
              {15'd0, gnt_valid, dny_valid, rsp_id, ntf_valid, ntf_id,
               ntf_size, id_err, ovf_err},
              {15'd0, ok, qv && !ok, qv ? 2'(qid) : 2'd0, rl,
               rl ? 2'(rid) : 2'd0, rl ? SW'(rsz) : SW'(0),
               (qv && !qk) || (rv && !rk), ovf});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) begin mpool[p] = 0; mreg[p] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        check("R11 reset", {22'd0, ready, init_err, gnt_valid, dny_valid,
              ntf_valid, id_err, ovf_err, ntf_size == 0, rsp_id},
              32'h4 << 0);
        // R9 query from a never-enrolled index
        op(1, 0, 0, 0, 0, 0, "R9 unenrolled query");
        // R3 init with no producers
        do_init("R3 empty init");
        enrol(0); enrol(1); enrol(3); enrol(0);  // R1 duplicate of 0
        // R11 enrolled but not ready: deny, release dropped
        op(1, 1, 8, 1, 1, 8, "R11 before ready");
        do_init("R2 init");
        do_init("R3 second init ignored");
        enrol(2);  // R1 late enrolment ignored
        op(1, 2, 8, 0, 0, 0, "R1 late enrol");
        // R5/R6/R7 sweep over producers and costs; R2 share = 10/3 = 3
        for (int id = 0; id < NP; id++) begin
            for (int c = 0; c <= 4; c++) begin
                op(1, id, c * FLIT + (c * 5) % FLIT, 0, 0, 0, "R5 sweep");
                if (last_gnt && c > 0)
                    op(0, 0, 0, 1, id, c * FLIT + 1, "R7 return");
            end
        end
        // R6 drain producer 0 then deny
        for (int k = 0; k < 3; k++) op(1, 0, FLIT, 0, 0, 0, "R5 drain");
        op(1, 0, FLIT, 0, 0, 0, "R6 empty deny");
        op(1, 0, FLIT - 1, 0, 0, 0, "R5 zero cost");
        op(1, 0, FLIT, 0, 0, 0, "R6 still empty");
        for (int k = 0; k < 3; k++) op(0, 0, 0, 1, 0, FLIT, "R7 refill");
        // R8 merged updates on producer 1
        op(1, 1, 2 * FLIT, 0, 0, 0, "R8 setup");
        op(1, 1, 2 * FLIT, 1, 1, 2 * FLIT, "R8 decision before release");
        op(1, 1, 3 * FLIT, 1, 1, FLIT, "R8 merge grant");
        op(1, 1, FLIT, 0, 0, 0, "R8 result");
        op(1, 1, FLIT, 0, 0, 0, "R8 result empty");
        op(0, 0, 0, 1, 1, 3 * FLIT, "R7 refill 1");
        // R10 overflow clamp on producer 3
        op(0, 0, 0, 1, 3, 2 * FLIT, "R10 overflow");
        op(1, 3, 3 * FLIT, 0, 0, 0, "R10 clamped grant");
        op(1, 3, FLIT, 0, 0, 0, "R10 clamped deny");
        op(0, 0, 0, 1, 3, 3 * FLIT, "R7 refill 3");
        // R9 release from unenrolled index
        op(0, 0, 0, 1, 2, FLIT, "R9 unenrolled release");
        // Different producers in one cycle
        op(1, 0, 3 * FLIT, 1, 1, 0, "R5 concurrent");
        op(1, 0, FLIT, 1, 0, 3 * FLIT, "R8 refill with deny");
        // R3 too many producers for a small buffer
        for (int id = 0; id < 3; id++) begin
            s_reg_valid = 1; s_reg_id = 2'(id);
            @(negedge clk);
        end
        s_reg_valid = 0;
        s_init = 1;
        @(negedge clk);
        s_init = 0;
        check("R3 buffer too small", {30'd0, s_ready, s_init_err}, 32'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule